// File: doc/BRIEF.md
# Single-Wire Bus Slot Engine

This block is the timing core of a master on a single-wire, open-drain bus. It generates one bus operation at a time: a bus reset with a check for a responding device, a write-zero slot, a write-one slot and a read slot. The line is never driven high during these slots. The block can only pull it low by raising `line_oe` while `line_out` stays 0. The released level comes from the external pull-up resistor, and the block watches it through `line_in`. Two static modes sit next to the slots. One actively drives the line high to feed devices powered from the bus. The other holds the line low to force a stuck device into a hard reset.

Commands enter through a valid/ready port. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole of a timed slot, so an upstream source must hold its command steady until it is taken. The response side has no back-pressure. `rsp_valid` is a single-cycle strobe and `rsp_bit` is meaningful only in that cycle. One timing parameter, the number of clock cycles per microsecond, scales every phase. The line input passes through a two-stage synchronizer before it is used.

Op codes on `cmd_op`:
- 0: bus reset
- 1: write 0
- 2: write 1
- 3: read
- 4: drive high
- 5: hold low
- 6 and 7: release

Top module: `owire_master`

## Requirements
- R1: After reset, `line_oe`=0, `line_out`=0, `cmd_ready`=1 and `rsp_valid`=0. The synchronizer stages start at 1.
- R2: Op 0 pulls the line low for 500 us and then releases it. It samples the line 60 us after the release. It strobes `rsp_valid` 981 us after acceptance, with `rsp_bit`=1 when the sampled level was low (a device answered).
- R3: Op 1 pulls the line low for 60 us and releases it for 1 us. It strobes `rsp_valid` 61 us after acceptance with `rsp_bit`=0.
- R4: Op 2 pulls the line low for 10 us and releases it for 51 us. It strobes `rsp_valid` 61 us after acceptance with `rsp_bit`=0.
- R5: Op 3 pulls the line low for 5 us and samples it 6 us after the release. It strobes `rsp_valid` 61 us after acceptance, with `rsp_bit` equal to the sampled level (high reads 1).
- R6: Op 4, accepted while idle, sets `line_oe`=1 and `line_out`=1 from the next cycle. These values persist until a release op is accepted. Acceptance strobes `rsp_valid` in the next cycle with `rsp_bit`=0.
- R7: Op 5, accepted while idle, sets `line_oe`=1 and `line_out`=0 from the next cycle. These values persist until a release op is accepted. Acceptance strobes `rsp_valid` in the next cycle with `rsp_bit`=0.
- R8: `cmd_ready` is 0 from the cycle after a slot op is accepted until the cycle its `rsp_valid` strobe appears. A command held during that time is taken at the first edge after `cmd_ready` returns to 1. `rsp_bit` is 0 whenever `rsp_valid` is 0. `line_out` is 1 only while `line_oe` is 1.
- R9: While driving high or holding low, ops 0 to 5 are consumed with no effect: the line outputs do not change and no strobe follows. A release op (6 or 7) returns the engine to idle with the line released and strobes `rsp_valid` in the next cycle. A release op accepted while idle only strobes.
- R10: The level used at a sample point is the value `line_in` had at the clock edge two cycles before the edge that ends the released phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 3 | Operation code |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_bit | output | 1 | Read value or device-answered flag |
| line_in | input | 1 | Level seen on the bus line |
| line_oe | output | 1 | Drive enable for the bus line |
| line_out | output | 1 | Value driven when enabled |

## Verification
The hardest case is a line level that changes within a couple of cycles of a sample point, because it shows exactly which edge the synchronized value comes from. The bench's device model flips its pull-down one cycle before the sample edge of a read slot and exactly at that edge. The cycle-by-cycle reference then shows whether the two-stage delay is honoured. A command held while a slot runs is the other case; the bench keeps it asserted and counts the cycles until it is taken.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_WR0     = 3'd1,
    OP_WR1     = 3'd2,
    OP_READ    = 3'd3,
    OP_DRV_HI  = 3'd4,
    OP_HOLD_LO = 3'd5,
    OP_REL_A   = 3'd6,
    OP_REL_B   = 3'd7
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_REL,
    ST_RECOV,
    ST_DRV_HI,
    ST_HOLD_LO
  } state_t;

  function automatic logic is_release(input logic [2:0] op);
    return op[2] & op[1];
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owire_timer.sv
module owire_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  a_r3_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/owire_fsm.sv
module owire_fsm
  import owire_pkg::*;
#(
  parameter int CW       = 10,
  parameter int RST_LOW  = 1000,
  parameter int RST_SAMP = 120,
  parameter int RST_REC  = 842,
  parameter int W0_LOW   = 120,
  parameter int W0_REL   = 2,
  parameter int W1_LOW   = 20,
  parameter int W1_REL   = 102,
  parameter int RD_LOW   = 10,
  parameter int RD_SAMP  = 12,
  parameter int RD_REC   = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  output logic          rsp_valid,
  output logic          rsp_bit,
  input  logic          line_sync,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          line_oe,
  output logic          line_out
);
  state_t     st;
  logic [1:0] cur;
  logic       samp_q;
  logic       accept;
  logic       seen;

  function automatic logic [CW-1:0] low_len(input logic [1:0] op);
    case (op)
      2'd0:    return CW'(RST_LOW - 1);
      2'd1:    return CW'(W0_LOW - 1);
      2'd2:    return CW'(W1_LOW - 1);
      default: return CW'(RD_LOW - 1);
    endcase
  endfunction

  function automatic logic [CW-1:0] rel_len(input logic [1:0] op);
    case (op)
      2'd0:    return CW'(RST_SAMP - 1);
      2'd1:    return CW'(W0_REL - 1);
      2'd2:    return CW'(W1_REL - 1);
      default: return CW'(RD_SAMP - 1);
    endcase
  endfunction

  function automatic logic [CW-1:0] rec_len(input logic [1:0] op);
    case (op)
      2'd0:    return CW'(RST_REC - 1);
      2'd3:    return CW'(RD_REC - 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic has_rec(input logic [1:0] op);
    return (op == 2'd0) || (op == 2'd3);
  endfunction

  always_comb begin
    cmd_ready = (st == ST_IDLE) || (st == ST_DRV_HI) || (st == ST_HOLD_LO);
    line_oe   = (st == ST_LOW) || (st == ST_DRV_HI) || (st == ST_HOLD_LO);
    line_out  = (st == ST_DRV_HI);
    accept    = cmd_valid && cmd_ready;
    seen      = (cur == 2'd0) ? ~line_sync : line_sync;
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: if (accept && !cmd_op[2]) begin
        tmr_load = 1'b1;
        tmr_val  = low_len(cmd_op[1:0]);
      end
      ST_LOW: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = rel_len(cur);
      end
      ST_REL: if (tmr_expired && has_rec(cur)) begin
        tmr_load = 1'b1;
        tmr_val  = rec_len(cur);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= 2'd0;
      samp_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_bit   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_bit   <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          if (!cmd_op[2]) begin
            st  <= ST_LOW;
            cur <= cmd_op[1:0];
          end else begin
            rsp_valid <= 1'b1;
            if (cmd_op == OP_DRV_HI)       st <= ST_DRV_HI;
            else if (cmd_op == OP_HOLD_LO) st <= ST_HOLD_LO;
          end
        end
        ST_LOW: if (tmr_expired) st <= ST_REL;
        ST_REL: if (tmr_expired) begin
          samp_q <= seen;
          if (has_rec(cur)) begin
            st <= ST_RECOV;
          end else begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b1;
          end
        end
        ST_RECOV: if (tmr_expired) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_bit   <= samp_q;
        end
        ST_DRV_HI, ST_HOLD_LO: if (accept && is_release(cmd_op)) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    line_out |-> line_oe);

  a_r6_drive_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRV_HI && !(cmd_valid && is_release(cmd_op))) |=> (line_oe && line_out));

  a_r7_hold_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD_LO && !(cmd_valid && is_release(cmd_op))) |=> (line_oe && !line_out));

  a_r2_recovery_ends_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOV && tmr_expired) |=> (rsp_valid && cmd_ready && !line_oe));

  a_r5_release_waits_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REL && !tmr_expired) |=> (st == ST_REL && !rsp_valid));
endmodule

// File: rtl/owire_master.sv
module owire_master #(
  parameter int CLKS_PER_US  = 50,
  parameter int RST_LOW_US   = 500,
  parameter int RST_SAMP_US  = 60,
  parameter int RST_REC_US   = 421,
  parameter int W0_LOW_US    = 60,
  parameter int W0_REL_US    = 1,
  parameter int W1_LOW_US    = 10,
  parameter int W1_REL_US    = 51,
  parameter int RD_LOW_US    = 5,
  parameter int RD_SAMP_US   = 6,
  parameter int RD_REC_US    = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  output logic       rsp_valid,
  output logic       rsp_bit,
  input  logic       line_in,
  output logic       line_oe,
  output logic       line_out
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_US = max2(max2(max2(RST_LOW_US, RST_SAMP_US), max2(RST_REC_US, W0_LOW_US)),
                               max2(max2(W1_REL_US, RD_REC_US), max2(W1_LOW_US, RD_SAMP_US)));
  localparam int CW     = $clog2(MAX_US * CLKS_PER_US + 1);

  logic          line_sync;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  owire_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (line_sync)
  );

  owire_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  owire_fsm #(
    .CW       (CW),
    .RST_LOW  (RST_LOW_US  * CLKS_PER_US),
    .RST_SAMP (RST_SAMP_US * CLKS_PER_US),
    .RST_REC  (RST_REC_US  * CLKS_PER_US),
    .W0_LOW   (W0_LOW_US   * CLKS_PER_US),
    .W0_REL   (W0_REL_US   * CLKS_PER_US),
    .W1_LOW   (W1_LOW_US   * CLKS_PER_US),
    .W1_REL   (W1_REL_US   * CLKS_PER_US),
    .RD_LOW   (RD_LOW_US   * CLKS_PER_US),
    .RD_SAMP  (RD_SAMP_US  * CLKS_PER_US),
    .RD_REC   (RD_REC_US   * CLKS_PER_US)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .rsp_valid   (rsp_valid),
    .rsp_bit     (rsp_bit),
    .line_sync   (line_sync),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .line_oe     (line_oe),
    .line_out    (line_out)
  );
endmodule

// File: tb/owire_master_bench.sv
module owire_master_bench;
  localparam int C = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [2:0] cmd_op;
  logic       rsp_valid;
  logic       rsp_bit;
  logic       line_in;
  logic       line_oe;
  logic       line_out;
  logic       dev_low;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  assign line_in = ~((line_oe & ~line_out) | dev_low);

  owire_master #(.CLKS_PER_US(C)) u_owire_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_bit   (rsp_bit),
    .line_in   (line_in),
    .line_oe   (line_oe),
    .line_out  (line_out)
  );

  function automatic int low_us(input int op);
    case (op) 0: return 500; 1: return 60; 2: return 10; default: return 5; endcase
  endfunction
  function automatic int rel_us(input int op);
    case (op) 0: return 60; 1: return 1; 2: return 51; default: return 6; endcase
  endfunction
  function automatic int rec_us(input int op);
    case (op) 0: return 421; 3: return 50; default: return 0; endcase
  endfunction
  function automatic string tag_of(input int m, input int op);
    if (m == 0) return "R1";
    if (m == 2) return "R6";
    if (m == 3) return "R7";
    case (op) 0: return "R2"; 1: return "R3"; 2: return "R4"; default: return "R5/R10"; endcase
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  // reference model: mode 0 idle, 1 timed slot, 2 drive high, 3 hold low
  int   m_mode, m_t, m_op;
  logic m_samp, m_l1, m_l2, e_done, e_bit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_t <= 0; m_op <= 0; m_samp <= 0;
      m_l1 <= 1; m_l2 <= 1; e_done <= 0; e_bit <= 0;
    end else begin
      m_l1   <= line_in;
      m_l2   <= m_l1;
      e_done <= 0;
      e_bit  <= 0;
      if (m_mode == 1) begin
        int sp, tot;
        sp  = (low_us(m_op) + rel_us(m_op)) * C;
        tot = sp + rec_us(m_op) * C;
        m_t <= m_t + 1;
        if (m_t + 1 == sp) begin
          m_samp <= (m_op == 0) ? ~m_l2 : m_l2;
          if (rec_us(m_op) == 0) begin
            m_mode <= 0; e_done <= 1;
          end
        end else if (m_t + 1 == tot) begin
          m_mode <= 0; e_done <= 1; e_bit <= m_samp;
        end
      end else if (cmd_valid) begin
        if (m_mode == 0) begin
          if (cmd_op < 4) begin m_mode <= 1; m_t <= 0; m_op <= int'(cmd_op); end
          else begin
            e_done <= 1;
            if (cmd_op == 4) m_mode <= 2;
            else if (cmd_op == 5) m_mode <= 3;
          end
        end else if (cmd_op >= 6) begin
          m_mode <= 0; e_done <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      logic  x_oe;
      tg   = tag_of(m_mode, m_op);
      x_oe = (m_mode == 1) ? (m_t < low_us(m_op) * C) : (m_mode >= 2);
      chk(line_oe == x_oe, tg, line_oe, x_oe);
      chk(line_out == (m_mode == 2), tg, line_out, m_mode == 2);
      chk(cmd_ready == (m_mode != 1), "R8", cmd_ready, m_mode != 1);
      chk(rsp_valid == e_done, tg, rsp_valid, e_done);
      chk(rsp_bit == e_bit, tg, rsp_bit, e_bit);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // present a command until it is taken; returns the number of falling edges waited
  task automatic send(input int op, output int waited);
    bit acc;
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    waited    = 0;
    forever begin
      acc = cmd_ready;
      @(negedge clk);
      waited++;
      if (acc) break;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int n, output logic b);
    n = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      n++;
    end
    b = rsp_bit;
  endtask

  task automatic run_op(input int op, input string tag, input int exp_cyc, input logic exp_bit);
    int w, n;
    logic b;
    send(op, w);
    wait_done(n, b);
    chk(n == exp_cyc, tag, n, exp_cyc);
    chk(b == exp_bit, tag, b, exp_bit);
    @(negedge clk);
  endtask

  initial begin
    int w, n;
    logic b;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; dev_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_oe == 0,   "R1", line_oe, 0);
    chk(line_out == 0,  "R1", line_out, 0);
    chk(cmd_ready == 1, "R1", cmd_ready, 1);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: bus reset with and without an answering device
    dev_low = 1'b1;
    run_op(0, "R2", 981 * C, 1'b1);
    dev_low = 1'b0;
    run_op(0, "R2", 981 * C, 1'b0);

    // R3, R4: write slots
    run_op(1, "R3", 61 * C, 1'b0);
    run_op(2, "R4", 61 * C, 1'b0);

    // R5: read slots at both levels
    dev_low = 1'b1;
    run_op(3, "R5", 61 * C, 1'b0);
    dev_low = 1'b0;
    run_op(3, "R5", 61 * C, 1'b1);

    // R10: level changes one cycle before and at the sample edge
    send(3, w);
    repeat ((5 + 6) * C - 2) @(negedge clk);
    dev_low = 1'b1;
    wait_done(n, b);
    chk(b == 1'b1, "R10", b, 1);
    dev_low = 1'b0;
    @(negedge clk);
    send(3, w);
    repeat ((5 + 6) * C - 3) @(negedge clk);
    dev_low = 1'b1;
    wait_done(n, b);
    chk(b == 1'b0, "R10", b, 0);
    dev_low = 1'b0;
    @(negedge clk);

    // R8: command held while a slot runs
    send(2, w);
    chk(w == 1, "R8", w, 1);
    send(3, w);
    chk(w == 61 * C + 1, "R8", w, 61 * C + 1);
    wait_done(n, b);
    @(negedge clk);

    // R6 + R9: drive high, dropped commands, release
    run_op(4, "R6", 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(line_oe && line_out, "R6", {line_oe, line_out}, 3);
    send(3, w);
    n = 0;
    repeat (6) begin @(negedge clk); if (rsp_valid) n++; end
    chk(n == 0, "R9", n, 0);
    chk(line_oe && line_out, "R9", {line_oe, line_out}, 3);
    run_op(6, "R9", 0, 1'b0);
    chk(!line_oe && !line_out, "R9", {line_oe, line_out}, 0);

    // R7 + R9: hold low, dropped reset, release
    run_op(5, "R7", 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(line_oe && !line_out, "R7", {line_oe, line_out}, 2);
    send(0, w);
    n = 0;
    repeat (6) begin @(negedge clk); if (rsp_valid) n++; end
    chk(n == 0, "R9", n, 0);
    chk(line_oe && !line_out, "R9", {line_oe, line_out}, 2);
    run_op(7, "R9", 0, 1'b0);
    chk(!line_oe, "R9", line_oe, 0);

    // R9: release while idle only strobes
    run_op(6, "R9", 0, 1'b0);
    chk(!line_oe && cmd_ready, "R9", {line_oe, cmd_ready}, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule